// File: doc/BRIEF.md
# Change-Triggered Timestamped Sample Recorder

This block watches an 8-channel logic bus and writes to a sample memory only when the channel pattern moves away from the last pattern it stored, so long quiet stretches take up no memory. A sample strobe, 6.25 MHz in the intended system, sets when the bus is evaluated. A free-running timestamp counts accepted strobes, so software can rebuild the waveform from the change points. Every stored event is a 32-bit record. The record holds the channel pattern, a status byte and the timestamp.

The record leaves the block as two 16-bit words on a plain synchronous write port: a write enable, a word address and write data. The low word goes to an even address and the timestamp word to the odd address above it. Three pulse inputs control capture: arm, halt and clear. Two level outputs report whether capture is armed and whether the memory has run out of record slots. At the default size the memory has 2^18 record slots, which is two 256K x 16 banks seen as one word space.

Top module: `chg_recorder`

## Requirements
- R1: After reset, `runFlag` and `fullFlag` are low and `ramWe` stays low until a record is stored.
- R2: A `startReq` pulse raises `runFlag`. A `stopReq` pulse lowers it. While halted, no word is written and the timestamp does not advance. After a later start, records continue at the next free address.
- R3: The first accepted strobe after a start always stores a record, changed or not, with status bit 0 set.
- R4: Any other accepted strobe stores a record only if the synchronised channels differ from the last stored pattern. Status bit 2 is set when they differ.
- R5: A stored record is written in the two cycles that follow the accepted strobe. The first word goes to even address 2k, with channels in [7:0] and status in [15:8]. The second word goes to address 2k+1 and holds the timestamp, zero-extended. The timestamp is the count of accepted strobes before the current one.
- R6: The timestamp wraps modulo 2^TS_W. A strobe that sees an all-ones timestamp always stores a record with status bit 1 set. Status bits 7:3 are zero.
- R7: Channels pass through two flip-flops before comparison. A channel change applied one clock before the strobe edge is not seen by that strobe.
- R8: Once the word of the last record slot is written, `fullFlag` rises and `runFlag` falls. No further word is written, and `startReq` has no effect until a clear.
- R9: A `clrReq` pulse clears the write address, the timestamp, `fullFlag` and `runFlag`.
- R10: When control pulses arrive in the same cycle, clear beats stop and stop beats start. A strobe in that cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Arm capture (one-cycle pulse) |
| stopReq | input | 1 | Halt capture (one-cycle pulse) |
| clrReq | input | 1 | Clear address, timestamp and flags (one-cycle pulse) |
| sampleStb | input | 1 | Sample strobe, at most one per three clocks |
| chIn | input | CH_W | Logic channels, asynchronous |
| ramWe | output | 1 | Memory word write enable |
| ramAddr | output | ADDR_W | Memory word address |
| ramWData | output | CH_W+8 | Memory write data |
| runFlag | output | 1 | Capture armed |
| fullFlag | output | 1 | No free record slot |

## Verification
The bench builds the block with ADDR_W=5 and TS_W=5. That gives 16 record slots and a timestamp that wraps after 32 strobes. With these sizes a few dozen strobes are enough to reach the wrap record, the full stop and the ignored restart.

The bench uses strobes spaced a few clocks apart. Some of them change the channels only one clock before the strobe, to test the synchroniser. Others are issued while capture is halted. Some put control pulses in the same cycle, to check which one wins.

// File: rtl/chg_rec_pkg.sv
package chg_rec_pkg;
  // status byte bit positions
  localparam int STAT_FIRST = 0;
  localparam int STAT_WRAP  = 1;
  localparam int STAT_CHG   = 2;
  localparam int STAT_W     = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic tsInc;
    logic tsClr;
    logic latch;
    logic firstMark;
    logic wordHi;
  } ecrStrobe_t;
endpackage

// File: rtl/chg_rec_dp.sv
module chg_rec_dp
  import chg_rec_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int TS_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CH_W-1:0]         chIn,
  input  ecrStrobe_t              stb,
  output logic                    needStore,
  output logic [CH_W+STAT_W-1:0]  wordData
);
  localparam int WORD_W = CH_W + STAT_W;

  logic [CH_W-1:0]   syncA, syncB, lastStored, recData;
  logic [STAT_W-1:0] recStatus;
  logic [TS_W-1:0]   tsCnt, recTs;
  logic              chgSeen, tsTop;
  logic [WORD_W-1:0] tsWord;

  always_comb begin
    chgSeen   = (syncB != lastStored);
    tsTop     = &tsCnt;
    needStore = chgSeen | tsTop;
  end

  // two-flop synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= chIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tsCnt <= '0;
    else if (stb.tsClr) tsCnt <= '0;
    else if (stb.tsInc) tsCnt <= tsCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastStored <= '0;
      recData    <= '0;
      recStatus  <= '0;
      recTs      <= '0;
    end else if (stb.latch) begin
      lastStored            <= syncB;
      recData               <= syncB;
      recTs                 <= tsCnt;
      recStatus             <= '0;
      recStatus[STAT_FIRST] <= stb.firstMark;
      recStatus[STAT_WRAP]  <= tsTop;
      recStatus[STAT_CHG]   <= chgSeen;
    end
  end

  always_comb begin
    tsWord = '0;
    tsWord[TS_W-1:0] = recTs;
    wordData = stb.wordHi ? tsWord : {recStatus, recData};
  end

  // R6
  ts_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tsInc && !stb.tsClr) |=> (tsCnt == $past(tsCnt) + 1'b1));
  // R2
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tsInc && !stb.tsClr) |=> $stable(tsCnt));
endmodule

// File: rtl/chg_rec_ctrl.sv
module chg_rec_ctrl
  import chg_rec_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              clrReq,
  input  logic              sampleStb,
  input  logic              needStore,
  output ecrStrobe_t        stb,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              runFlag,
  output logic              fullFlag
);
  localparam int REC_W = ADDR_W - 1;

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_t;

  phase_t           phase;
  logic [REC_W-1:0] recAddr;
  logic             running, full, firstPending, accept, lastSlot;

  always_comb begin
    accept        = sampleStb & running & ~clrReq & ~stopReq & (phase == PH_IDLE);
    lastSlot      = &recAddr;
    stb.tsInc     = accept;
    stb.tsClr     = clrReq;
    stb.latch     = accept & (firstPending | needStore);
    stb.firstMark = firstPending;
    stb.wordHi    = (phase == PH_HI);
    ramWe         = (phase != PH_IDLE);
    ramAddr       = {recAddr, (phase == PH_HI)};
    runFlag       = running;
    fullFlag      = full;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      recAddr      <= '0;
      running      <= 1'b0;
      full         <= 1'b0;
      firstPending <= 1'b0;
    end else if (clrReq) begin
      phase        <= PH_IDLE;
      recAddr      <= '0;
      running      <= 1'b0;
      full         <= 1'b0;
      firstPending <= 1'b0;
    end else begin
      if (stb.latch) firstPending <= 1'b0;
      if (stopReq) running <= 1'b0;
      else if (startReq && !full) begin
        running      <= 1'b1;
        firstPending <= 1'b1;
      end
      case (phase)
        PH_IDLE: if (stb.latch) phase <= PH_LO;
        PH_LO:   phase <= PH_HI;
        PH_HI: begin
          phase   <= PH_IDLE;
          recAddr <= recAddr + 1'b1;
          if (lastSlot) begin
            full    <= 1'b1;
            running <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R5
  we_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && !ramAddr[0] && !clrReq) |=> (ramWe && ramAddr == $past(ramAddr) + 1'b1));
  // R8
  full_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !runFlag);
  // R8
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !ramWe);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> (!fullFlag && !runFlag && !ramWe && ramAddr == '0));
endmodule

// File: rtl/chg_recorder.sv
module chg_recorder
  import chg_rec_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int TS_W   = 16,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              clrReq,
  input  logic              sampleStb,
  input  logic [CH_W-1:0]   chIn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [CH_W+7:0]   ramWData,
  output logic              runFlag,
  output logic              fullFlag
);
  ecrStrobe_t ctlStb;
  logic       needStore;

  chg_rec_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .clrReq(clrReq), .sampleStb(sampleStb), .needStore(needStore),
    .stb(ctlStb), .ramWe(ramWe), .ramAddr(ramAddr),
    .runFlag(runFlag), .fullFlag(fullFlag)
  );

  chg_rec_dp #(.CH_W(CH_W), .TS_W(TS_W)) u_dp (
    .clk(clk), .rstN(rstN), .chIn(chIn), .stb(ctlStb),
    .needStore(needStore), .wordData(ramWData)
  );
endmodule

// File: tb/chg_recorder_bench.sv
module chg_recorder_bench;
  localparam int CH_W   = 8;
  localparam int TS_W   = 5;
  localparam int ADDR_W = 5;
  localparam int NREC   = 1 << (ADDR_W - 1);
  localparam int TSMAX  = (1 << TS_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, stopReq = 1'b0, clrReq = 1'b0, sampleStb = 1'b0;
  logic [CH_W-1:0] chIn = '0;
  logic ramWe, runFlag, fullFlag;
  logic [ADDR_W-1:0] ramAddr;
  logic [CH_W+7:0] ramWData;

  always #10 clk = ~clk;

  chg_recorder #(.CH_W(CH_W), .TS_W(TS_W), .ADDR_W(ADDR_W)) u_chg_recorder (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .clrReq(clrReq), .sampleStb(sampleStb), .chIn(chIn), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWData(ramWData), .runFlag(runFlag), .fullFlag(fullFlag)
  );

  int checks = 0;
  int failures = 0;
  int wc = 0;
  int lastWrAddr = -1;
  bit done = 0;

  int    qAddr[$];
  int    qData[$];
  string qTag[$];

  // reference model state
  bit mRun = 0, mFull = 0, mFirst = 0;
  int mTs = 0, mRec = 0;
  logic [7:0] mLast = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit s, input bit p, input bit c);
    @(negedge clk);
    startReq = s; stopReq = p; clrReq = c;
    @(negedge clk);
    startReq = 0; stopReq = 0; clrReq = 0;
    if (c) begin mRun = 0; mFull = 0; mTs = 0; mRec = 0; end
    else if (p) mRun = 0;
    else if (s && !mFull) begin mRun = 1; mFirst = 1; end
  endtask

  task automatic step(input logic [7:0] val, input int lead);
    logic [7:0] seen;
    int st;
    string tag;
    seen = (lead >= 3) ? val : chIn;
    @(negedge clk);
    chIn = val;
    repeat (lead - 1) @(negedge clk);
    if (mRun) begin
      if (mFirst || seen != mLast || mTs == TSMAX) begin
        st = (mFirst ? 1 : 0) | ((mTs == TSMAX) ? 2 : 0) | ((seen != mLast) ? 4 : 0);
        tag = mFirst ? "R3" : ((mTs == TSMAX) ? "R6" : "R4");
        qAddr.push_back(2 * mRec);     qData.push_back((st << 8) | seen); qTag.push_back(tag);
        qAddr.push_back(2 * mRec + 1); qData.push_back(mTs);               qTag.push_back(tag);
        mLast = seen; mFirst = 0; mRec++;
        if (mRec == NREC) begin mFull = 1; mRun = 0; end
      end
      mTs = (mTs + 1) & TSMAX;
    end
    sampleStb = 1;
    @(negedge clk);
    sampleStb = 0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && ramWe) begin
        wc++;
        lastWrAddr = int'(ramAddr);
        if (qAddr.size() == 0) chk(0, "R4 unexpected write", int'(ramAddr), -1);
        else begin
          int ea, ed;
          string t;
          ea = qAddr.pop_front(); ed = qData.pop_front(); t = qTag.pop_front();
          chk(int'(ramAddr) == ea, {t, " R5 addr"}, int'(ramAddr), ea);
          chk(int'(ramWData) == ed, {t, " R5 data"}, int'(ramWData), ed);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!runFlag && !fullFlag && !ramWe, "R1 reset flags", {runFlag, fullFlag, ramWe}, 0);

    pulse(1, 0, 0);
    chk(runFlag, "R2 start", runFlag, 1);
    step(8'h00, 3);
    step(8'h00, 3); step(8'h00, 3);
    step(8'h5A, 3); step(8'hA5, 3); step(8'hA5, 3);
    chk(wc == 6, "R4 only changes stored", wc, 6);

    w = wc;
    step(8'h3C, 1);
    chk(wc == w, "R7 late change unseen", wc, w);
    step(8'h3C, 3);
    chk(wc == w + 2, "R7 change seen after sync", wc, w + 2);

    pulse(0, 1, 0);
    chk(!runFlag, "R2 stop", runFlag, 0);
    w = wc;
    step(8'hFF, 3); step(8'h00, 3); step(8'h3C, 3);
    chk(wc == w, "R2 no writes while halted", wc, w);
    pulse(1, 0, 0);
    step(8'h3C, 3);
    chk(lastWrAddr == 9, "R2 resumes at next address", lastWrAddr, 9);

    w = TSMAX + 1 - mTs;
    repeat (w) step(8'h3C, 3);
    chk(lastWrAddr == 11, "R6 wrap record stored", lastWrAddr, 11);

    while (!mFull) step(mRec[0] ? 8'h11 : 8'h22, 3);
    chk(fullFlag && !runFlag, "R8 full halts", {fullFlag, runFlag}, 2);
    w = wc;
    step(8'h77, 3); step(8'h11, 3);
    pulse(1, 0, 0);
    chk(!runFlag && wc == w, "R8 start ignored when full", {runFlag, wc[3:0]}, w & 15);

    pulse(0, 0, 1);
    chk(!fullFlag && !runFlag, "R9 clear flags", {fullFlag, runFlag}, 0);
    pulse(1, 0, 0);
    step(8'h77, 3);
    chk(lastWrAddr == 1, "R9 address restarts", lastWrAddr, 1);

    pulse(1, 1, 0);
    chk(!runFlag, "R10 stop beats start", runFlag, 0);
    pulse(1, 0, 1);
    chk(!runFlag && !fullFlag, "R10 clear beats start", runFlag, 0);
    w = wc;
    step(8'h12, 3);
    chk(wc == w, "R10 no capture after clear", wc, w);

    repeat (4) @(negedge clk);
    chk(qAddr.size() == 0, "R5 all records written", qAddr.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule